// File: doc/BRIEF.md
# CAN Identifier Acceptance Matcher

This block chooses where an incoming CAN frame should be stored. It takes the frame's 29-bit identifier field, a flag that marks the frame as standard or extended, and a one-cycle valid strobe. It then tests that identifier against every active receive filter and reports the winner. A winner is either one of the receive FIFO's filter elements or one of the receive mailboxes. The result carries a hit flag, the winning index and a flag that tells whether the index refers to the FIFO. The receive engine around the block uses that answer to write the frame into the right place.

Each filter holds a programmed identifier, a format flag and an acceptance mask. A set mask bit makes that identifier bit significant. A cleared mask bit turns it into a don't-care. Two masking schemes are available, chosen by one configuration bit. In the per-buffer scheme, every slot takes the mask register that carries its own number. In the global scheme, mailboxes 14 and 15 each have a dedicated mask, every other mailbox shares one common mask, and the FIFO filter elements use a FIFO mask.

When the FIFO is switched on, its filters are consulted first, and the lowest mailbox slots are handed over to it. Mailbox matching then begins at the first slot after the reserved group. A mailbox takes part only when it is set up for reception.

Top module: `can_id_acceptance`

## Requirements
- R1: A filter accepts a frame only when every identifier bit whose mask bit is 1 equals the programmed bit. Identifier bits whose mask bit is 0 have no effect on the result.
- R2: The frame's format flag (1 = extended, 0 = standard) must equal the filter's format flag. For a standard frame, only identifier bits 28..18 are compared, and bits 17..0 are ignored.
- R3: With `cfg_per_buf_mask` = 1, mailbox n uses `buf_mask[n]` and FIFO filter element k uses `buf_mask[k]`.
- R4: With `cfg_per_buf_mask` = 0, mailbox 14 uses `mask_mb14` and mailbox 15 uses `mask_mb15`. Every other mailbox uses `mask_mb_common`, and the FIFO filter elements use `mask_fifo`.
- R5: With `cfg_fifo_en` = 1, mailboxes 0..7 never match and the eight FIFO filter elements take part. With `cfg_fifo_en` = 0, the FIFO filter elements never match.
- R6: Only mailboxes with `mb_is_rx` = 1 can match. A transmit mailbox is ignored.
- R7: Any FIFO filter hit beats every mailbox hit. Among FIFO filters the lowest index wins, and among mailboxes the lowest index wins.
- R8: `res_done` is 1 exactly in the cycle after a cycle with `frm_valid` = 1, and is 0 otherwise. `res_hit`, `res_fifo` and `res_idx` are valid with it. When nothing matches, `res_hit`, `res_fifo` and `res_idx` are all 0.
- R9: While reset is held, and after it, until the first result, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frm_valid | input | 1 | One-cycle strobe: a frame identifier is present |
| frm_id | input | 29 | Identifier field; a standard identifier sits in bits 28..18 |
| frm_ext | input | 1 | 1 = extended frame, 0 = standard frame |
| cfg_fifo_en | input | 1 | Enables the receive FIFO and reserves the lowest mailboxes for it |
| cfg_per_buf_mask | input | 1 | 1 = per-buffer masks, 0 = global masking scheme |
| mb_is_rx | input | NUM_MB | Per-mailbox direction, 1 = receive |
| mb_id | input | NUM_MB x 29 | Programmed mailbox identifiers |
| mb_ext | input | NUM_MB | Mailbox format flags |
| ff_id | input | 8 x 29 | Programmed FIFO filter identifiers |
| ff_ext | input | 8 | FIFO filter format flags |
| buf_mask | input | NUM_MB x 29 | Per-buffer mask registers |
| mask_mb_common | input | 29 | Common mailbox mask for the global scheme |
| mask_mb14 | input | 29 | Dedicated mask for mailbox 14 in the global scheme |
| mask_mb15 | input | 29 | Dedicated mask for mailbox 15 in the global scheme |
| mask_fifo | input | 29 | FIFO filter mask for the global scheme |
| res_done | output | 1 | One-cycle result pulse |
| res_hit | output | 1 | A filter accepted the frame |
| res_fifo | output | 1 | The winner is a FIFO filter element |
| res_idx | output | $clog2(NUM_MB) | Winning FIFO filter or mailbox index |

## Verification
The comparison logic is purely combinational and a single register stage captures the result. All four outputs therefore belong to the clock edge that sees `frm_valid` high, and `res_done` drops again one edge later. The bench raises the strobe on a falling edge and drops it on the next falling edge. It then reads every output at that same falling edge, which falls half a period after the capturing rising edge. After some frames it waits one more falling edge to confirm that `res_done` has returned to 0. Configuration inputs are changed only while no frame is pending, so every result reflects the setup that was in place when the strobe was sampled.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

    localparam int ID_W     = 29;
    localparam int STD_W    = 11;
    localparam int N_FFLT   = 8;
    localparam int MB14     = 14;
    localparam int MB15     = 15;

    typedef logic [ID_W-1:0] can_id_t;

    typedef struct packed {
        can_id_t id;
        logic    ext;
    } rx_frame_t;

    typedef struct packed {
        logic hit;
        logic fifo;
    } match_kind_t;

    localparam can_id_t STD_FIELD = {{STD_W{1'b1}}, {(ID_W-STD_W){1'b0}}};

    function automatic can_id_t eff_mask(input can_id_t mask, input logic ext);
        return ext ? mask : (mask & STD_FIELD);
    endfunction

    function automatic logic id_accept(input rx_frame_t frm, input can_id_t flt_id,
                                       input logic flt_ext, input can_id_t mask);
        can_id_t diff;
        diff = (frm.id ^ flt_id) & eff_mask(mask, frm.ext);
        return (frm.ext == flt_ext) && (diff == '0);
    endfunction

endpackage

// File: rtl/can_acc_mask_sel.sv
module can_acc_mask_sel
    import can_acc_pkg::*;
#(
    parameter int NUM_MB = 16
) (
    input  logic                  per_buf,
    input  can_id_t [NUM_MB-1:0]  buf_mask,
    input  can_id_t               mask_mb_common,
    input  can_id_t               mask_mb14,
    input  can_id_t               mask_mb15,
    input  can_id_t               mask_fifo,
    output can_id_t [NUM_MB-1:0]  mb_mask,
    output can_id_t [N_FFLT-1:0]  ff_mask
);

    for (genvar n = 0; n < NUM_MB; n++) begin : g_mb
        if (n == MB14) begin : g_m14
            assign mb_mask[n] = per_buf ? buf_mask[n] : mask_mb14;
        end else if (n == MB15) begin : g_m15
            assign mb_mask[n] = per_buf ? buf_mask[n] : mask_mb15;
        end else begin : g_mc
            assign mb_mask[n] = per_buf ? buf_mask[n] : mask_mb_common;
        end
    end

    for (genvar k = 0; k < N_FFLT; k++) begin : g_ff
        assign ff_mask[k] = per_buf ? buf_mask[k] : mask_fifo;
    end

endmodule

// File: rtl/can_acc_cmp.sv
module can_acc_cmp
    import can_acc_pkg::*;
#(
    parameter int N = 16
) (
    input  rx_frame_t         frm,
    input  can_id_t [N-1:0]   flt_id,
    input  logic    [N-1:0]   flt_ext,
    input  can_id_t [N-1:0]   flt_mask,
    input  logic    [N-1:0]   part,
    output logic    [N-1:0]   hits
);

    for (genvar i = 0; i < N; i++) begin : g_slot
        assign hits[i] = part[i] && id_accept(frm, flt_id[i], flt_ext[i], flt_mask[i]);
    end

endmodule

// File: rtl/can_acc_prio.sv
module can_acc_prio #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;

endmodule

// File: rtl/can_id_acceptance.sv
module can_id_acceptance
    import can_acc_pkg::*;
#(
    parameter int NUM_MB = 16,
    localparam int IDX_W = $clog2(NUM_MB)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         frm_valid,
    input  logic [28:0]                  frm_id,
    input  logic                         frm_ext,
    input  logic                         cfg_fifo_en,
    input  logic                         cfg_per_buf_mask,
    input  logic [NUM_MB-1:0]            mb_is_rx,
    input  logic [NUM_MB-1:0][28:0]      mb_id,
    input  logic [NUM_MB-1:0]            mb_ext,
    input  logic [7:0][28:0]             ff_id,
    input  logic [7:0]                   ff_ext,
    input  logic [NUM_MB-1:0][28:0]      buf_mask,
    input  logic [28:0]                  mask_mb_common,
    input  logic [28:0]                  mask_mb14,
    input  logic [28:0]                  mask_mb15,
    input  logic [28:0]                  mask_fifo,
    output logic                         res_done,
    output logic                         res_hit,
    output logic                         res_fifo,
    output logic [IDX_W-1:0]             res_idx
);

    localparam int FF_IDX_W = $clog2(N_FFLT);

    rx_frame_t              frm;
    can_id_t [NUM_MB-1:0]   mb_mask;
    can_id_t [N_FFLT-1:0]   ff_mask;
    logic    [NUM_MB-1:0]   mb_part;
    logic    [NUM_MB-1:0]   mb_hits;
    logic    [N_FFLT-1:0]   ff_part;
    logic    [N_FFLT-1:0]   ff_hits;
    logic                   mb_any;
    logic                   ff_any;
    logic    [IDX_W-1:0]    mb_win;
    logic    [FF_IDX_W-1:0] ff_win;
    match_kind_t            kind_d;
    logic    [IDX_W-1:0]    idx_d;
    logic    [NUM_MB-1:0]   rx_snap;
    logic                   fifo_snap;

    assign frm.id  = frm_id;
    assign frm.ext = frm_ext;

    // Slots 0..N_FFLT-1 are handed to the FIFO while it is on.
    for (genvar n = 0; n < NUM_MB; n++) begin : g_part
        if (n < N_FFLT) begin : g_rsv
            assign mb_part[n] = mb_is_rx[n] && !cfg_fifo_en;
        end else begin : g_free
            assign mb_part[n] = mb_is_rx[n];
        end
    end
    assign ff_part = {N_FFLT{cfg_fifo_en}};

    can_acc_mask_sel #(.NUM_MB(NUM_MB)) u_mask (
        .per_buf        (cfg_per_buf_mask),
        .buf_mask       (buf_mask),
        .mask_mb_common (mask_mb_common),
        .mask_mb14      (mask_mb14),
        .mask_mb15      (mask_mb15),
        .mask_fifo      (mask_fifo),
        .mb_mask        (mb_mask),
        .ff_mask        (ff_mask)
    );

    can_acc_cmp #(.N(NUM_MB)) u_cmp_mb (
        .frm      (frm),
        .flt_id   (mb_id),
        .flt_ext  (mb_ext),
        .flt_mask (mb_mask),
        .part     (mb_part),
        .hits     (mb_hits)
    );

    can_acc_cmp #(.N(N_FFLT)) u_cmp_ff (
        .frm      (frm),
        .flt_id   (ff_id),
        .flt_ext  (ff_ext),
        .flt_mask (ff_mask),
        .part     (ff_part),
        .hits     (ff_hits)
    );

    can_acc_prio #(.N(NUM_MB), .IDX_W(IDX_W)) u_prio_mb (
        .req (mb_hits),
        .any (mb_any),
        .idx (mb_win)
    );

    can_acc_prio #(.N(N_FFLT), .IDX_W(FF_IDX_W)) u_prio_ff (
        .req (ff_hits),
        .any (ff_any),
        .idx (ff_win)
    );

    always_comb begin
        kind_d = '{hit: 1'b0, fifo: 1'b0};
        idx_d  = '0;
        if (ff_any) begin
            kind_d = '{hit: 1'b1, fifo: 1'b1};
            idx_d  = IDX_W'(ff_win);
        end else if (mb_any) begin
            kind_d = '{hit: 1'b1, fifo: 1'b0};
            idx_d  = mb_win;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_done  <= 1'b0;
            res_hit   <= 1'b0;
            res_fifo  <= 1'b0;
            res_idx   <= '0;
            rx_snap   <= '0;
            fifo_snap <= 1'b0;
        end else begin
            res_done <= frm_valid;
            if (frm_valid) begin
                res_hit   <= kind_d.hit;
                res_fifo  <= kind_d.fifo;
                res_idx   <= idx_d;
                rx_snap   <= mb_is_rx;
                fifo_snap <= cfg_fifo_en;
            end
        end
    end

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> res_done);                                                   // R8
    AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> !res_done);                                                 // R8
    AST_MISS_IS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (res_done && !res_hit) |-> (!res_fifo && res_idx == '0));                  // R8
    AST_FIFO_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_fifo) |-> fifo_snap);                                     // R5
    AST_RSV_SKIPPED: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_hit && !res_fifo && fifo_snap) |-> (int'(res_idx) >= N_FFLT)); // R5
    AST_WIN_IS_RX: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_hit && !res_fifo) |-> rx_snap[res_idx]);                  // R6
    AST_FIFO_IDX_RANGE: assert property (@(posedge clk) disable iff (rst)
        (res_done && res_fifo) |-> (int'(res_idx) < N_FFLT));                      // R7

endmodule

// File: tb/tb_can_id_acceptance.sv
module tb_can_id_acceptance;

    localparam int NUM_MB = 16;
    localparam int IDX_W  = $clog2(NUM_MB);
    localparam logic [28:0] ONES = '1;

    logic clk = 1'b0;
    logic rst;
    logic frm_valid;
    logic [28:0] frm_id;
    logic frm_ext;
    logic cfg_fifo_en;
    logic cfg_per_buf_mask;
    logic [NUM_MB-1:0] mb_is_rx;
    logic [NUM_MB-1:0][28:0] mb_id;
    logic [NUM_MB-1:0] mb_ext;
    logic [7:0][28:0] ff_id;
    logic [7:0] ff_ext;
    logic [NUM_MB-1:0][28:0] buf_mask;
    logic [28:0] mask_mb_common, mask_mb14, mask_mb15, mask_fifo;
    logic res_done, res_hit, res_fifo;
    logic [IDX_W-1:0] res_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    can_id_acceptance #(.NUM_MB(NUM_MB)) dut (
        .clk(clk), .rst(rst), .frm_valid(frm_valid), .frm_id(frm_id), .frm_ext(frm_ext),
        .cfg_fifo_en(cfg_fifo_en), .cfg_per_buf_mask(cfg_per_buf_mask),
        .mb_is_rx(mb_is_rx), .mb_id(mb_id), .mb_ext(mb_ext),
        .ff_id(ff_id), .ff_ext(ff_ext), .buf_mask(buf_mask),
        .mask_mb_common(mask_mb_common), .mask_mb14(mask_mb14), .mask_mb15(mask_mb15),
        .mask_fifo(mask_fifo),
        .res_done(res_done), .res_hit(res_hit), .res_fifo(res_fifo), .res_idx(res_idx)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic defaults();
        cfg_fifo_en = 1'b0;
        cfg_per_buf_mask = 1'b0;
        mb_is_rx = '0;
        mb_ext = '1;
        ff_ext = '1;
        for (int n = 0; n < NUM_MB; n++) begin
            mb_id[n]    = 29'h1F00_0000 | 29'(n * 29'h111);
            buf_mask[n] = ONES;
        end
        for (int k = 0; k < 8; k++) ff_id[k] = 29'h1E00_0000 | 29'(k * 29'h222);
        mask_mb_common = ONES;
        mask_mb14 = ONES;
        mask_mb15 = ONES;
        mask_fifo = ONES;
    endtask

    // Strobe one frame; outputs are read half a period after the capturing edge.
    task automatic send(input logic [28:0] id, input logic ext);
        @(negedge clk);
        frm_id = id;
        frm_ext = ext;
        frm_valid = 1'b1;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic expect_res(input bit hit, input bit fifo, input int idx, input string req);
        int act, exp;
        act = {res_done, res_hit, res_fifo, 8'(res_idx)};
        exp = {1'b1, hit, fifo, 8'(idx)};
        check(act == exp, req, act, exp);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        frm_valid = 1'b0;
        frm_id = '0;
        frm_ext = 1'b0;
        defaults();
        repeat (3) @(negedge clk);
        check({res_done, res_hit, res_fifo, res_idx} == '0, "R9 during reset",
              int'({res_done, res_hit, res_fifo, res_idx}), 0);
        rst = 1'b0;
        @(negedge clk);
        check({res_done, res_hit, res_fifo, res_idx} == '0, "R9 after reset",
              int'({res_done, res_hit, res_fifo, res_idx}), 0);
    endtask

    task automatic t_mask_bits();
        defaults();
        mb_is_rx[3] = 1'b1;
        mb_id[3] = 29'h0123_4567;
        send(29'h0123_4567, 1'b1);
        expect_res(1, 0, 3, "R1 exact match");
        send(29'h0123_4467, 1'b1);
        expect_res(0, 0, 0, "R1 masked bit differs");
        mask_mb_common = ONES & ~29'h0000_0100;
        send(29'h0123_4467, 1'b1);
        expect_res(1, 0, 3, "R1 cleared mask bit is dont-care");
    endtask

    task automatic t_format();
        defaults();
        mb_is_rx[3] = 1'b1;
        mb_ext[3] = 1'b0;
        mb_id[3] = {11'h123, 18'h0};
        send({11'h123, 18'h0}, 1'b1);
        expect_res(0, 0, 0, "R2 format mismatch rejected");
        send({11'h123, 18'h2_ABCD}, 1'b0);
        expect_res(1, 0, 3, "R2 standard ignores low bits");
        send({11'h124, 18'h0}, 1'b0);
        expect_res(0, 0, 0, "R2 standard bits compared");
    endtask

    task automatic t_global();
        defaults();
        mb_is_rx[5] = 1'b1;
        mb_is_rx[14] = 1'b1;
        mb_is_rx[15] = 1'b1;
        mb_id[5]  = 29'h0AAA_AAA0;
        mb_id[14] = 29'h0AAA_AAA0;
        mb_id[15] = 29'h0BBB_BBB0;
        mask_mb14 = ONES & ~29'h1;
        buf_mask[5] = ONES & ~29'h1;
        send(29'h0AAA_AAA1, 1'b1);
        expect_res(1, 0, 14, "R4 mb14 dedicated mask, mb5 common mask");
        mask_mb15 = ONES & ~29'h1;
        send(29'h0BBB_BBB1, 1'b1);
        expect_res(1, 0, 15, "R4 mb15 dedicated mask");
        cfg_fifo_en = 1'b1;
        ff_id[6] = 29'h0CCC_CCC0;
        mask_fifo = ONES & ~29'h3;
        send(29'h0CCC_CCC3, 1'b1);
        expect_res(1, 1, 6, "R4 FIFO mask");
    endtask

    task automatic t_per_buf();
        defaults();
        cfg_per_buf_mask = 1'b1;
        mb_is_rx[5] = 1'b1;
        mb_id[5] = 29'h0AAA_AAA0;
        buf_mask[5] = ONES & ~29'h1;
        send(29'h0AAA_AAA1, 1'b1);
        expect_res(1, 0, 5, "R3 mailbox own mask");
        mb_is_rx[14] = 1'b1;
        mb_id[14] = 29'h0DDD_DDD0;
        mask_mb14 = ONES & ~29'h1;
        send(29'h0DDD_DDD1, 1'b1);
        expect_res(0, 0, 0, "R3 dedicated mask unused in per-buffer scheme");
        cfg_fifo_en = 1'b1;
        buf_mask[2] = '0;
        send(29'h0555_5555, 1'b1);
        expect_res(1, 1, 2, "R3 FIFO filter uses buffer mask by number");
    endtask

    task automatic t_fifo_rsv();
        defaults();
        mb_is_rx[2] = 1'b1;
        mb_is_rx[9] = 1'b1;
        mb_id[2] = 29'h0777_0000;
        mb_id[9] = 29'h0777_0000;
        ff_id[1] = 29'h0888_0000;
        send(29'h0888_0000, 1'b1);
        expect_res(0, 0, 0, "R5 FIFO filters off when disabled");
        send(29'h0777_0000, 1'b1);
        expect_res(1, 0, 2, "R5 low mailbox used when FIFO off");
        cfg_fifo_en = 1'b1;
        send(29'h0777_0000, 1'b1);
        expect_res(1, 0, 9, "R5 reserved mailboxes skipped");
        send(29'h0888_0000, 1'b1);
        expect_res(1, 1, 1, "R5 FIFO filter active");
    endtask

    task automatic t_dir();
        defaults();
        mb_id[4] = 29'h0999_0000;
        send(29'h0999_0000, 1'b1);
        expect_res(0, 0, 0, "R6 transmit mailbox ignored");
        mb_is_rx[4] = 1'b1;
        send(29'h0999_0000, 1'b1);
        expect_res(1, 0, 4, "R6 receive mailbox matches");
    endtask

    task automatic t_prio();
        defaults();
        cfg_fifo_en = 1'b1;
        mb_is_rx = '1;
        mb_id[10] = 29'h0444_0000;
        mb_id[12] = 29'h0444_0000;
        mb_id[9]  = 29'h0444_0000;
        send(29'h0444_0000, 1'b1);
        expect_res(1, 0, 9, "R7 lowest mailbox wins");
        ff_id[5] = 29'h0444_0000;
        ff_id[3] = 29'h0444_0000;
        send(29'h0444_0000, 1'b1);
        expect_res(1, 1, 3, "R7 FIFO beats mailbox, lowest filter wins");
    endtask

    task automatic t_timing();
        defaults();
        mb_is_rx[8] = 1'b1;
        mb_id[8] = 29'h0333_0000;
        send(29'h0333_0000, 1'b1);
        expect_res(1, 0, 8, "R8 result one cycle after strobe");
        @(negedge clk);
        check(res_done == 1'b0, "R8 done is a single pulse", int'(res_done), 0);
        repeat (3) @(negedge clk);
        check(res_done == 1'b0, "R8 no done without strobe", int'(res_done), 0);
        send(29'h0333_0001, 1'b1);
        expect_res(0, 0, 0, "R8 miss reports zeros");
    endtask

    initial begin
        t_reset();
        t_mask_bits();
        t_format();
        t_global();
        t_per_buf();
        t_fifo_rsv();
        t_dir();
        t_prio();
        t_timing();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule